// File: doc/BRIEF.md
# Convolution Window Address Controller

This block drives the read side of a small image buffer and a coefficient ROM while a serial multiply-accumulate unit applies a 3x3 kernel to every pixel of a stored image. For each output pixel (a "window") it presents the nine kernel taps one after another. For each tap it gives the coefficient index and the X/Y read address of the matching neighbour pixel. Addresses that would fall outside the image are clamped to the nearest edge. The image buffer answers in the same cycle the address is presented, so the address and the coefficient index leave the block together.

The run is gated by a mode input. While the mode input is low the controller sits in IDLE with every output at zero, and the buffer stays with the external pixel-write path. When the mode input goes high, windows are visited with the vertical position running fastest: after each finished window Y advances by one, and after Y has covered all 16 rows, X advances by one. Each tap is handed over only when the arithmetic unit signals ready. After the ninth tap, the strobe stays high until the arithmetic unit reports the window done. The strobe then drops for one cycle before the next window begins. After window (15,15) a one-cycle done pulse is given. The controller then waits until the mode input has been taken low and raised again.

States: ST_IDLE, ST_ISSUE (taps handed over), ST_DRAIN (waiting for the window result), ST_GAP (strobe low between windows), ST_FINISH (done pulse), ST_HOLD (run complete, waiting for the mode input to drop). Transitions:
- go (IDLE to ISSUE, mode high).
- tap step (ISSUE to ISSUE, ready high on taps 0 to 7).
- last tap (ISSUE to DRAIN).
- window done (DRAIN to GAP).
- image done (DRAIN to FINISH, on window (15,15)).
- resume (GAP to ISSUE).
- park (FINISH to HOLD).
- release (HOLD to IDLE, mode low).
- abort (any state to IDLE whenever the mode input is low).

Top module: `conv_win_ctrl`

## Requirements
- R1: A synchronous active-high reset returns the controller to idle with the strobe and done outputs low and the coefficient index and both addresses at zero, even when the mode input is high during reset.
- R2: While the mode input is low, the strobe, done, coefficient index and both addresses are zero one cycle later, whatever the ready and done feedback does. Dropping the mode input in the middle of a run abandons it, and the next rise of the mode input starts again at window X=0, Y=0.
- R3: Within a window the coefficient index runs 0,1,...,8 in order. It advances by one exactly after a cycle in which it is presented with the strobe high and ready high, and it holds otherwise.
- R4: While tap k (0 to 8) is presented for window (X,Y), the read address is X + (k mod 3) − 1 and Y + (k div 3) − 1, each clamped to 0..15, and it appears in the same cycle as the coefficient index.
- R5: After the ninth tap is accepted, the strobe stays high with the index and addresses at zero, and ready is ignored, until the done feedback arrives. In the cycle after done, the strobe is low for exactly one cycle, and then tap 0 of the next window is presented.
- R6: Windows are visited with Y incrementing after each window. When Y wraps from 15 to 0, X increments. A full run covers all 256 windows, ending at (15,15).
- R7: In the cycle after the done feedback of window (15,15), the done output is high with the strobe low, for exactly one cycle.
- R8: After a completed run the controller starts no new window while the mode input stays high. A new run needs the mode input low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Mode: high runs the convolution, low leaves the buffer to the write path |
| mac_ready_i | input | 1 | Arithmetic unit takes the presented tap this cycle |
| mac_done_i | input | 1 | Arithmetic unit has finished the current window |
| conv_o | output | 1 | Convolve strobe to the arithmetic unit |
| coef_idx_o | output | 4 | Coefficient ROM index of the presented tap |
| rd_x_o | output | 4 | Image read address, X |
| rd_y_o | output | 4 | Image read address, Y |
| done_o | output | 1 | One-cycle pulse after the last window |

## Verification
The assertions take the mode input and both feedback inputs to be synchronous to the clock. They assume the done feedback is a single-cycle pulse that comes only after all nine taps of a window have been taken. The bench's model of the arithmetic unit keeps to this rule: it answers ready at random only while it still owes taps, and it raises done for one cycle after a random wait once the ninth tap is in. During that wait it also toggles ready freely. Aborts and restarts are made only by the mode input, at chosen points of the run.

// File: rtl/conv_win_pkg.sv
package conv_win_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_GAP,
        ST_FINISH,
        ST_HOLD
    } cw_state_e;

endpackage

// File: rtl/cw_wrap_cnt.sv
module cw_wrap_cnt #(
    parameter int LIMIT = 3,
    parameter int VW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [VW-1:0] value,
    output logic          wrap
);

    localparam logic [VW-1:0] TOP = VW'(LIMIT - 1);

    // carry out to the next counter of the chain
    assign wrap = inc && (value == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            value <= '0;
        end else if (inc) begin
            value <= wrap ? '0 : value + 1'b1;
        end
    end

endmodule

// File: rtl/cw_axis_clamp.sv
module cw_axis_clamp #(
    parameter int SIZE = 16,
    parameter int KDIM = 3,
    parameter int BW   = $clog2(SIZE),
    parameter int OW   = (KDIM > 1) ? $clog2(KDIM) : 1
) (
    input  logic [BW-1:0] base,
    input  logic [OW-1:0] off,
    output logic [BW-1:0] pos
);

    int sum;

    always_comb begin
        sum = int'(base) + int'(off) - (KDIM / 2);
        if (sum < 0) begin
            pos = '0;
        end else if (sum > SIZE - 1) begin
            pos = BW'(SIZE - 1);
        end else begin
            pos = BW'(sum);
        end
    end

endmodule

// File: rtl/conv_win_ctrl.sv
module conv_win_ctrl
    import conv_win_pkg::*;
#(
    parameter int IMG_W = 16,
    parameter int IMG_H = 16,
    parameter int KDIM  = 3,
    parameter int XW    = $clog2(IMG_W),
    parameter int YW    = $clog2(IMG_H),
    parameter int CW    = $clog2(KDIM * KDIM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          mac_ready_i,
    input  logic          mac_done_i,
    output logic          conv_o,
    output logic [CW-1:0] coef_idx_o,
    output logic [XW-1:0] rd_x_o,
    output logic [YW-1:0] rd_y_o,
    output logic          done_o
);

    localparam int TW = (KDIM > 1) ? $clog2(KDIM) : 1;
    localparam logic [TW-1:0] TAP_LAST = TW'(KDIM - 1);
    localparam logic [XW-1:0] X_LAST   = XW'(IMG_W - 1);
    localparam logic [YW-1:0] Y_LAST   = YW'(IMG_H - 1);

    cw_state_e state_q, state_d;

    logic [TW-1:0] tap_col, tap_row;
    logic [XW-1:0] win_x;
    logic [YW-1:0] win_y;
    logic          col_wrap, row_wrap, y_wrap, x_wrap;
    logic          tap_step, win_step, cnt_clr;
    logic          last_tap, last_win;
    logic [XW-1:0] clamp_x;
    logic [YW-1:0] clamp_y;

    assign last_tap = (tap_row == TAP_LAST) && (tap_col == TAP_LAST);
    assign last_win = (win_x == X_LAST) && (win_y == Y_LAST);
    assign tap_step = start_i && (state_q == ST_ISSUE) && mac_ready_i;
    assign win_step = start_i && (state_q == ST_DRAIN) && mac_done_i && !last_win;
    assign cnt_clr  = (state_q == ST_IDLE);

    // tap column -> tap row chain (one 3x3 window)
    cw_wrap_cnt #(.LIMIT(KDIM), .VW(TW)) u_col (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(tap_step),
        .value(tap_col), .wrap(col_wrap)
    );
    cw_wrap_cnt #(.LIMIT(KDIM), .VW(TW)) u_row (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(col_wrap),
        .value(tap_row), .wrap(row_wrap)
    );

    // window Y -> window X chain (whole image)
    cw_wrap_cnt #(.LIMIT(IMG_H), .VW(YW)) u_win_y (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(win_step),
        .value(win_y), .wrap(y_wrap)
    );
    cw_wrap_cnt #(.LIMIT(IMG_W), .VW(XW)) u_win_x (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(y_wrap),
        .value(win_x), .wrap(x_wrap)
    );

    // edge clamping, column offset on X and row offset on Y
    cw_axis_clamp #(.SIZE(IMG_W), .KDIM(KDIM), .BW(XW), .OW(TW)) u_clamp_x (
        .base(win_x), .off(tap_col), .pos(clamp_x)
    );
    cw_axis_clamp #(.SIZE(IMG_H), .KDIM(KDIM), .BW(YW), .OW(TW)) u_clamp_y (
        .base(win_y), .off(tap_row), .pos(clamp_y)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (!start_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_ISSUE;
                ST_ISSUE:  state_d = (tap_step && last_tap) ? ST_DRAIN : ST_ISSUE;
                ST_DRAIN: begin
                    if (mac_done_i) begin
                        state_d = last_win ? ST_FINISH : ST_GAP;
                    end
                end
                ST_GAP:    state_d = ST_ISSUE;
                ST_FINISH: state_d = ST_HOLD;
                ST_HOLD:   state_d = ST_HOLD;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        conv_o     = 1'b0;
        done_o     = 1'b0;
        coef_idx_o = '0;
        rd_x_o     = '0;
        rd_y_o     = '0;
        unique case (state_q)
            ST_ISSUE: begin
                conv_o     = 1'b1;
                coef_idx_o = CW'(int'(tap_row) * KDIM + int'(tap_col));
                rd_x_o     = clamp_x;
                rd_y_o     = clamp_y;
            end
            ST_DRAIN:  conv_o = 1'b1;
            ST_FINISH: done_o = 1'b1;
            ST_IDLE, ST_GAP, ST_HOLD: begin
            end
            default: begin
            end
        endcase
    end

    logic unused_carry;
    assign unused_carry = row_wrap ^ x_wrap;

endmodule

// File: rtl/conv_win_ctrl_chk.sv
module conv_win_ctrl_chk
    import conv_win_pkg::*;
#(
    parameter int CW   = 4,
    parameter int NTAP = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          mac_ready_i,
    input logic          mac_done_i,
    input logic          conv_o,
    input logic          done_o,
    input logic [CW-1:0] coef_idx_o,
    input cw_state_e     state_q
);

    localparam logic [CW-1:0] IDX_LAST = CW'(NTAP - 1);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !conv_o && !done_o && coef_idx_o == '0);

    a_r2_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> !conv_o && !done_o);

    a_r3_tap_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ISSUE && start_i && !mac_ready_i) |=> $stable(coef_idx_o) && conv_o);

    a_r3_tap_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ISSUE && start_i && mac_ready_i && coef_idx_o != IDX_LAST)
        |=> coef_idx_o == CW'($past(coef_idx_o) + 1'b1));

    a_r5_drain_entry: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ISSUE && start_i && mac_ready_i && coef_idx_o == IDX_LAST)
        |=> conv_o && coef_idx_o == '0);

    a_r5_gap_low: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && start_i && mac_done_i) |=> !conv_o);

    a_r7_single_done: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && start_i) |=> !conv_o && !done_o);

endmodule

bind conv_win_ctrl conv_win_ctrl_chk #(.CW(CW), .NTAP(KDIM * KDIM)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .mac_ready_i(mac_ready_i),
    .mac_done_i(mac_done_i), .conv_o(conv_o), .done_o(done_o),
    .coef_idx_o(coef_idx_o), .state_q(state_q)
);

// File: tb/conv_win_ctrl_tb.sv
module conv_win_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int H  = 16;
    localparam int K  = 3;
    localparam int NT = K * K;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       mac_ready_i = 1'b0;
    logic       mac_done_i = 1'b0;
    logic       conv_o, done_o;
    logic [3:0] coef_idx_o, rd_x_o, rd_y_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    conv_win_ctrl u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mac_ready_i(mac_ready_i),
        .mac_done_i(mac_done_i), .conv_o(conv_o), .coef_idx_o(coef_idx_o),
        .rd_x_o(rd_x_o), .rd_y_o(rd_y_o), .done_o(done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampc(input int v, input int n);
        if (v < 0) return 0;
        if (v > n - 1) return n - 1;
        return v;
    endfunction

    task automatic expect_quiet(input string req);
        chk(conv_o == 1'b0, req, int'(conv_o), 0);
        chk(done_o == 1'b0, req, int'(done_o), 0);
        chk(coef_idx_o == 4'd0, req, int'(coef_idx_o), 0);
        chk(rd_x_o == 4'd0, req, int'(rd_x_o), 0);
        chk(rd_y_o == 4'd0, req, int'(rd_y_o), 0);
    endtask

    // model of a serial MAC; rmode 1 = always ready
    task automatic run_windows(input int first, input int n, input bit rmode, input bit ends_run);
        for (int w = first; w < first + n; w++) begin
            int wx, wy, taps, d, ex, ey;
            bit r;
            wx = w / H;
            wy = w % H;
            taps = 0;
            while (taps < NT) begin
                @(negedge clk);
                ex = clampc(wx + taps % K - 1, W);
                ey = clampc(wy + taps / K - 1, H);
                chk(conv_o == 1'b1, "R5 strobe while taps owed", int'(conv_o), 1);
                chk(int'(coef_idx_o) == taps, "R3 coefficient order", int'(coef_idx_o), taps);
                chk(int'(rd_x_o) == ex, "R4,R6 read address x", int'(rd_x_o), ex);
                chk(int'(rd_y_o) == ey, "R4,R6 read address y", int'(rd_y_o), ey);
                r = rmode ? 1'b1 : 1'($urandom % 2);
                mac_ready_i = r;
                mac_done_i = 1'b0;
                if (r) taps++;
            end
            d = int'($urandom % 3);
            repeat (d) begin
                @(negedge clk);
                chk(conv_o == 1'b1, "R5 strobe held in drain", int'(conv_o), 1);
                chk(coef_idx_o == 4'd0, "R5 index parked in drain", int'(coef_idx_o), 0);
                mac_ready_i = 1'($urandom % 2);
            end
            @(negedge clk);
            chk(conv_o == 1'b1, "R5 strobe before done", int'(conv_o), 1);
            mac_ready_i = 1'b0;
            mac_done_i = 1'b1;
            @(negedge clk);
            mac_done_i = 1'b0;
            if (ends_run && w == W * H - 1) begin
                chk(done_o == 1'b1, "R7 done pulse", int'(done_o), 1);
                chk(conv_o == 1'b0, "R7 strobe low at done", int'(conv_o), 0);
            end else begin
                chk(conv_o == 1'b0, "R5 gap cycle", int'(conv_o), 0);
                chk(done_o == 1'b0, "R7 no early done", int'(done_o), 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5eed));
        // R1: reset dominates a high mode input
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        expect_quiet("R1 reset state");
        rst = 1'b0;

        // full random run over all windows
        run_windows(0, W * H, 1'b0, 1'b1);

        // R8: parked while mode stays high
        repeat (6) begin
            @(negedge clk);
            expect_quiet("R8 no restart while high");
        end

        // R2: mode low, feedback toggling has no effect
        start_i = 1'b0;
        mac_ready_i = 1'b1;
        mac_done_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            expect_quiet("R2 idle with mode low");
        end
        mac_ready_i = 1'b0;
        mac_done_i = 1'b0;
        start_i = 1'b1;

        // directed always-ready run, then abort mid-window
        run_windows(0, 20, 1'b1, 1'b0);
        @(negedge clk);
        chk(conv_o == 1'b1, "R6 window 20 begins", int'(conv_o), 1);
        start_i = 1'b0;
        mac_ready_i = 1'b1;
        @(negedge clk);
        expect_quiet("R2 abort");
        mac_ready_i = 1'b0;
        @(negedge clk);
        expect_quiet("R2 abort held");
        start_i = 1'b1;

        // restart begins at the origin
        run_windows(0, 18, 1'b0, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        expect_quiet("R2 final stop");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3 run stalled actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule